// File: doc/BRIEF.md
# Power-Switch Request Interrupt Registers

This block collects bus-power and I/O-voltage switch requests raised by a card-controller core and turns them into an interrupt for software. Each of the four request inputs is edge-detected. A rising edge latches a sticky status bit. A maskable OR of the status bits drives the interrupt line.

Software services a request in three steps. It reads the status register, clears the serviced bits by writing ones to the clear register, and writes the outcome to the control register. A control write sends one-cycle success pulses back to the core, one line for the bus-power pair and one for the I/O-voltage pair. The register port is a plain 32-bit write strobe with address and data. Read data is combinational on the address.

The acknowledge path is a two-state sequencer. ACK_IDLE holds while no control write occurs. A control write moves it to ACK_HOLD, where the captured success bits drive the pulses for one cycle. The next cycle returns it to ACK_IDLE, or keeps it in ACK_HOLD with new bits if another control write arrives.

Top module: `pwrsw_irq_regs`

## Requirements
- R1: After reset the status reads 0, the mask reads 0xF, the control reads 0, and `irq`, `ack_bus` and `ack_io` are low.
- R2: A 0-to-1 transition on `req_in[i]` sets status bit i one clock later. The bit meanings are: bit 0 bus-off, bit 1 bus-on, bit 2 I/O-low, bit 3 I/O-high. Holding the input high does not set the bit again after it is cleared.
- R3: A read of offset 0xDC returns the status in bits [3:0] and zeros above. Writes to 0xDC have no effect.
- R4: Writing 1 to bit i of offset 0xE4 clears status bit i. Written zeros leave their bits unchanged. Offset 0xE4 reads as 0.
- R5: When a rising edge on input i and a clear of bit i occur in the same cycle, status bit i ends up set.
- R6: `irq` is high exactly when some status bit is set and its mask bit is 1. The mask is read/write at offset 0xE0 in bits [3:0], and its upper bits read as 0.
- R7: A write to offset 0xE8 with bit 0 set pulses `ack_bus` high for the one cycle after the write. Bit 2 set does the same for `ack_io`. Other bits produce no pulse.
- R8: The control register reads back the written bits 0 and 2 only during the pulse cycle, and reads 0 afterwards.
- R9: Status bits stay set, through any number of cycles and input changes, until cleared.
- R10: Reads of unmapped offsets return 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| req_in | input | 4 | Switch request levels from the core |
| irq | output | 1 | Interrupt to software |
| ack_bus | output | 1 | Bus-power switch success pulse |
| ack_io | output | 1 | I/O-voltage switch success pulse |

## Verification
The checker watches four things on every cycle:
- status bits stay set until a clear write names them (R9);
- a status bit only appears after its input was high (R2);
- each acknowledge pulse follows a control write with the matching bit (R7);
- each pulse lasts one cycle unless the write is repeated, and readback bits above the field are zero (R3, R6).

Only the bench's directed scenarios can show the exact cycle of each effect and the value of each register after reset. They also cover set-versus-clear collisions, mask gating of the interrupt, and the silence of unmapped offsets and the read-only status.

// File: rtl/pwrsw_pkg.sv
package pwrsw_pkg;
    localparam logic [7:0] OFF_STATUS = 8'hDC;
    localparam logic [7:0] OFF_MASK   = 8'hE0;
    localparam logic [7:0] OFF_CLEAR  = 8'hE4;
    localparam logic [7:0] OFF_CTRL   = 8'hE8;

    localparam int BUS_OK_BIT = 0;
    localparam int IO_OK_BIT  = 2;

    typedef enum logic {
        ACK_IDLE = 1'b0,
        ACK_HOLD = 1'b1
    } ack_state_e;
endpackage

// File: rtl/pwrsw_req_capture.sv
module pwrsw_req_capture #(
    parameter int N_REQ = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_REQ-1:0] req_in,
    input  logic [N_REQ-1:0] clr_bits,
    output logic [N_REQ-1:0] status_o
);
    logic [N_REQ-1:0] req_q;

    for (genvar i = 0; i < N_REQ; i++) begin : g_bit
        logic rise;
        logic stat_q;

        assign rise = req_in[i] & ~req_q[i];

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                req_q[i] <= 1'b0;
                stat_q   <= 1'b0;
            end else begin
                req_q[i] <= req_in[i];
                // a fresh edge overrides a clear in the same cycle
                stat_q   <= rise | (stat_q & ~clr_bits[i]);
            end
        end

        assign status_o[i] = stat_q;
    end
endmodule

// File: rtl/pwrsw_ack_seq.sv
module pwrsw_ack_seq
    import pwrsw_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctrl_wr,
    input  logic       bus_ok_in,
    input  logic       io_ok_in,
    output logic       ack_bus,
    output logic       ack_io,
    output logic [1:0] ctrl_view
);
    ack_state_e state_q, state_d;
    logic [1:0] held_q, held_d;

    always_comb begin
        state_d = ACK_IDLE;
        held_d  = 2'b00;
        unique case (state_q)
            ACK_IDLE, ACK_HOLD: begin
                if (ctrl_wr) begin
                    state_d = ACK_HOLD;
                    held_d  = {io_ok_in, bus_ok_in};
                end
            end
            default: state_d = ACK_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ACK_IDLE;
            held_q  <= 2'b00;
        end else begin
            state_q <= state_d;
            held_q  <= held_d;
        end
    end

    always_comb begin
        ack_bus   = 1'b0;
        ack_io    = 1'b0;
        ctrl_view = 2'b00;
        unique case (state_q)
            ACK_HOLD: begin
                ack_bus   = held_q[0];
                ack_io    = held_q[1];
                ctrl_view = held_q;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/pwrsw_irq_regs.sv
module pwrsw_irq_regs
    import pwrsw_pkg::*;
#(
    parameter int N_REQ  = 4,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [N_REQ-1:0]  req_in,
    output logic              irq,
    output logic              ack_bus,
    output logic              ack_io
);
    localparam logic [N_REQ-1:0] MASK_RST = {N_REQ{1'b1}};

    logic             hit_status, hit_mask, hit_clear, hit_ctrl;
    logic [N_REQ-1:0] status_q;
    logic [N_REQ-1:0] mask_q;
    logic [N_REQ-1:0] clr_bits;
    logic [1:0]       ctrl_view;
    logic             unused_wdata;

    assign hit_status = (addr == ADDR_W'(OFF_STATUS));
    assign hit_mask   = (addr == ADDR_W'(OFF_MASK));
    assign hit_clear  = (addr == ADDR_W'(OFF_CLEAR));
    assign hit_ctrl   = (addr == ADDR_W'(OFF_CTRL));

    assign clr_bits     = (wr_en && hit_clear) ? wdata[N_REQ-1:0] : '0;
    assign unused_wdata = ^wdata[DATA_W-1:N_REQ];

    pwrsw_req_capture #(.N_REQ(N_REQ)) u_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_in   (req_in),
        .clr_bits (clr_bits),
        .status_o (status_q)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= MASK_RST;
        end else if (wr_en && hit_mask) begin
            mask_q <= wdata[N_REQ-1:0];
        end
    end

    pwrsw_ack_seq u_ack (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_wr   (wr_en && hit_ctrl),
        .bus_ok_in (wdata[BUS_OK_BIT]),
        .io_ok_in  (wdata[IO_OK_BIT]),
        .ack_bus   (ack_bus),
        .ack_io    (ack_io),
        .ctrl_view (ctrl_view)
    );

    assign irq = |(status_q & mask_q);

    always_comb begin
        rdata = '0;
        if (hit_status) begin
            rdata[N_REQ-1:0] = status_q;
        end else if (hit_mask) begin
            rdata[N_REQ-1:0] = mask_q;
        end else if (hit_ctrl) begin
            rdata[BUS_OK_BIT] = ctrl_view[0];
            rdata[IO_OK_BIT]  = ctrl_view[1];
        end
    end
endmodule

// File: rtl/pwrsw_irq_regs_chk.sv
module pwrsw_irq_regs_chk
    import pwrsw_pkg::*;
#(
    parameter int N_REQ  = 4,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] rdata,
    input logic [N_REQ-1:0]  req_in,
    input logic [N_REQ-1:0]  status_q,
    input logic              ack_bus,
    input logic              ack_io
);
    logic ctrl_wr, clr_wr;
    assign ctrl_wr = wr_en && (addr == ADDR_W'(OFF_CTRL));
    assign clr_wr  = wr_en && (addr == ADDR_W'(OFF_CLEAR));

    // R9: set bits persist unless a clear write names them
    p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(status_q) & ~($past(clr_wr) ? $past(wdata[N_REQ-1:0]) : '0))
                   & ~status_q) == '0));

    // R2: a newly set bit needs its input high in the previous cycle
    p_set_source_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_q & ~$past(status_q) & ~$past(req_in)) == '0));

    // R7: each acknowledge pulse is caused by a matching control write
    p_bus_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ack_bus |-> $past(ctrl_wr && wdata[BUS_OK_BIT]));
    p_io_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ack_io |-> $past(ctrl_wr && wdata[IO_OK_BIT]));

    // R7: a pulse lasts one cycle without a repeated write
    p_bus_width_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_bus && !ctrl_wr) |=> !ack_bus);

    // R3, R6: readback of status and mask carries nothing above the field
    p_upper_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((addr == ADDR_W'(OFF_STATUS)) || (addr == ADDR_W'(OFF_MASK)))
            |-> (rdata[DATA_W-1:N_REQ] == '0));
endmodule

bind pwrsw_irq_regs pwrsw_irq_regs_chk #(
    .N_REQ(N_REQ), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .req_in(req_in), .status_q(status_q),
    .ack_bus(ack_bus), .ack_io(ack_io)
);

// File: tb/pwrsw_irq_regs_test.sv
module pwrsw_irq_regs_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = 8'h00;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [3:0]  req_in = 4'h0;
    logic        irq, ack_bus, ack_io;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    pwrsw_irq_regs uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .req_in(req_in), .irq(irq), .ack_bus(ack_bus), .ack_io(ack_io)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive at negedge, let one posedge pass, return at the next negedge
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; addr = 8'h00; wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        addr = a; #1; d = rdata; addr = 8'h00;
    endtask

    task automatic tick; @(negedge clk); endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(8'hDC, v); check("R1 status", v, 32'h0);
        rd(8'hE0, v); check("R1 mask", v, 32'hF);
        rd(8'hE8, v); check("R1 ctrl", v, 32'h0);
        check("R1 outputs", {29'b0, irq, ack_bus, ack_io}, 32'h0);
    endtask

    task automatic t_edge_set;
        logic [31:0] v;
        req_in = 4'b0101; tick;
        rd(8'hDC, v); check("R2 edge sets bus-off and io-low", v, 32'h5);
        check("R6 irq with full mask", {31'b0, irq}, 32'h1);
        req_in = 4'b0000; repeat (3) tick;
        rd(8'hDC, v); check("R9 sticky after input drop", v, 32'h5);
        wr(8'hE4, 32'h5);
        rd(8'hDC, v); check("R4 clear both", v, 32'h0);
        req_in = 4'b1000; tick;
        wr(8'hE4, 32'h8);
        repeat (2) tick;
        rd(8'hDC, v); check("R2 held level does not re-set", v, 32'h0);
        req_in = 4'b0000; tick;
    endtask

    task automatic t_status_ro_clear;
        logic [31:0] v;
        req_in = 4'b0110; tick; req_in = 4'b0000;
        wr(8'hDC, 32'h0);
        rd(8'hDC, v); check("R3 status write ignored", v, 32'h6);
        wr(8'hE4, 32'h4);
        rd(8'hDC, v); check("R4 zeros keep bits", v, 32'h2);
        rd(8'hE4, v); check("R4 clear reads zero", v, 32'h0);
        wr(8'hE4, 32'hFFFF_FFFF);
        rd(8'hDC, v); check("R4 clear all", v, 32'h0);
    endtask

    task automatic t_set_wins;
        logic [31:0] v;
        req_in = 4'b0010; tick; req_in = 4'b0000; tick;
        req_in = 4'b0010;
        wr(8'hE4, 32'h2);
        rd(8'hDC, v); check("R5 set beats clear", v, 32'h2);
        req_in = 4'b0000;
        wr(8'hE4, 32'h2);
    endtask

    task automatic t_mask;
        logic [31:0] v;
        wr(8'hE0, 32'hFFFF_FFF6);
        rd(8'hE0, v); check("R6 mask readback", v, 32'h6);
        req_in = 4'b1000; tick; req_in = 4'b0000;
        check("R6 masked bit no irq", {31'b0, irq}, 32'h0);
        req_in = 4'b0100; tick; req_in = 4'b0000;
        check("R6 enabled bit irq", {31'b0, irq}, 32'h1);
        wr(8'hE4, 32'h4);
        check("R6 irq drops after clear", {31'b0, irq}, 32'h0);
        wr(8'hE0, 32'hF);
        check("R6 unmask pending raises irq", {31'b0, irq}, 32'h1);
        wr(8'hE4, 32'hF);
    endtask

    task automatic t_ack;
        logic [31:0] v;
        wr_en = 1'b1; addr = 8'hE8; wdata = 32'hFFFF_FFFF;
        @(negedge clk);
        wr_en = 1'b0; addr = 8'h00; wdata = '0;
        check("R7 pulses after write", {30'b0, ack_bus, ack_io}, 32'h3);
        rd(8'hE8, v); check("R8 ctrl readback during pulse", v, 32'h5);
        tick;
        check("R7 pulses end", {30'b0, ack_bus, ack_io}, 32'h0);
        rd(8'hE8, v); check("R8 ctrl self-cleared", v, 32'h0);
        wr(8'hE8, 32'h4);
        check("R7 io only", {30'b0, ack_bus, ack_io}, 32'h1);
        wr(8'hE8, 32'hA);
        check("R7 other bits no pulse", {30'b0, ack_bus, ack_io}, 32'h0);
    endtask

    task automatic t_unmapped;
        logic [31:0] v;
        req_in = 4'b0001; tick; req_in = 4'b0000;
        wr(8'h40, 32'hFFFF_FFFF);
        wr(8'hE1, 32'h0);
        rd(8'h40, v); check("R10 unmapped reads zero", v, 32'h0);
        rd(8'hDC, v); check("R10 status untouched", v, 32'h1);
        rd(8'hE0, v); check("R10 mask untouched", v, 32'hF);
        check("R10 no ack", {30'b0, ack_bus, ack_io}, 32'h0);
        wr(8'hE4, 32'h1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick;
        t_reset;
        t_edge_set;
        t_status_ro_clear;
        t_set_wins;
        t_mask;
        t_ack;
        t_unmapped;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule